// File: doc/BRIEF.md
# Selectable 1:2 Sample Output Demultiplexer

This block sits after an 8-bit conversion core. It takes one sample code on every rising edge of the sample clock and presents the codes on two output ports. A mode input picks one of two behaviours, and the mode may change at run time.

In interleaved mode the block makes a half-rate output clock. It sends successive samples to the two ports in turn, so each port changes at half the sample rate. The half-rate clock is placed so that the port being read is stable around its edges. In full-rate mode every sample goes to one port, and the clock output is the inverse of the sample clock.

A synchronous active-low alignment input pins the half-rate clock low for as long as it is held. The edge that releases it fixes the phase of the divider. Several instances released on the same edge therefore produce identical output phases. A polarity input can complement the output codes.

Top module: `sample_demux`

## Requirements
- R1: While `dmux_mode` is 1, every rising edge of `clk` that samples `align_n` low leaves `clk_out` low after that edge. Holding `align_n` low for more edges keeps `clk_out` low for more periods.
- R2: The first rising edge that samples `align_n` high after it was low drives `clk_out` high, in interleaved mode. From then on `clk_out` toggles on every rising edge, giving half the sample rate.
- R3: In interleaved mode, the sample captured on the release edge appears on `port_b` after the next rising edge. The sample after it appears on `port_a` one edge later. The ports keep alternating, and each port holds its value for two clock periods.
- R4: In interleaved mode, `port_b` changes only on the edge where `clk_out` falls, and `port_a` changes only on the edge where `clk_out` rises.
- R5: In full-rate mode (`dmux_mode` = 0), every sample captured on an edge appears on `port_b` after the following edge. This is the same latency as in interleaved mode. `port_a` keeps its last value.
- R6: In full-rate mode `clk_out` equals the inverse of `clk`: 0 while `clk` is high and 1 while it is low.
- R7: In full-rate mode `align_n` has no effect on `port_b`, which keeps following the samples while `align_n` is low.
- R8: With `code_true` = 1 a sample is output unchanged, so full scale gives 8'hFF and zero gives 8'h00. With `code_true` = 0 every bit is complemented. The value of `code_true` is taken on the same edge as the sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all registers act on its rising edge |
| align_n | input | 1 | Synchronous active-low phase alignment of the half-rate clock |
| dmux_mode | input | 1 | 1 = interleaved two-port output, 0 = full-rate single-port output |
| code_true | input | 1 | 1 = output codes unchanged, 0 = output codes complemented |
| sample_in | input | W (8) | Sample code from the conversion core |
| port_a | output | W (8) | Second interleaved lane; holds in full-rate mode |
| port_b | output | W (8) | First interleaved lane; carries every sample in full-rate mode |
| clk_out | output | 1 | Half-rate clock, or the inverted sample clock in full-rate mode |

## Verification
The hardest case to reach is the divider phase around the alignment input. To see it, the bench must find the exact edge on which `align_n` is first sampled high, and then follow which port takes which sample from that edge on. The bench changes `align_n` only at falling clock edges, so the release edge is known exactly. It then feeds a counting pattern, which lets the bench work out which sample each port should hold after every edge. It also holds the alignment input low for several edges in a row, to show the reset period grows with it. In full-rate mode it drives the alignment input low to show the data keeps flowing.

// File: rtl/sdm_pkg.sv
// Package sdm_pkg
// Shared width and lane encoding for the sample demultiplexer.
// Assumes a two-lane output, where lane index 1 is port B.
package sdm_pkg;
    localparam int CODE_W = 8;
    localparam int LANES  = 2;

    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;
endpackage

// File: rtl/sdm_capture.sv
// Module sdm_capture
// First pipeline stage: registers the incoming code on every rising edge
// and applies the polarity choice. There is no reset; the data path never
// depends on the alignment input.
module sdm_capture #(
    parameter int W = sdm_pkg::CODE_W
) (
    input  logic         clk,
    input  logic         code_true,
    input  logic [W-1:0] sample_in,
    output logic [W-1:0] cap_q
);
    // Polarity stage: complement every bit when code_true is 0.
    logic [W-1:0] pol_code;

    for (genvar b = 0; b < W; b++) begin : g_pol
        assign pol_code[b] = sample_in[b] ^ ~code_true;
    end

    // Capture the code in polarity form on each sample edge.
    always_ff @(posedge clk) begin
        cap_q <= pol_code;
    end
endmodule

// File: rtl/sdm_phase.sv
// Module sdm_phase
// Divide-by-two phase register with synchronous active-low alignment.
// It is held low on every edge that samples align_n low. The releasing
// edge sets it high, and after that it toggles on every edge.
module sdm_phase (
    input  logic clk,
    input  logic align_n,
    output logic phase_q
);
    // Half-rate toggle, pinned low during alignment.
    always_ff @(posedge clk) begin
        if (!align_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    AST_ALIGN_HOLDS_LOW: assert property (@(posedge clk)
        !align_n |=> !phase_q);                                        // R1

    AST_RELEASE_RISES: assert property (@(posedge clk) disable iff (!align_n)
        (align_n && !$past(align_n)) |=> phase_q);                     // R2

    AST_HALF_RATE_TOGGLE: assert property (@(posedge clk) disable iff (!align_n)
        (align_n && $past(align_n)) |-> (phase_q != $past(phase_q)));  // R2
endmodule

// File: rtl/sdm_steer.sv
// Module sdm_steer
// Output lane registers. In interleaved mode the lane given by the phase
// loads the captured code: phase high loads lane B, phase low loads lane A.
// In full-rate mode only lane B loads. There is no reset, so lanes that are
// not loaded keep their value.
module sdm_steer #(
    parameter int W = sdm_pkg::CODE_W,
    parameter int N = sdm_pkg::LANES
) (
    input  logic         clk,
    input  logic         align_n,
    input  logic         dmux_mode,
    input  logic         phase_q,
    input  logic [W-1:0] cap_q,
    output logic [W-1:0] port_a,
    output logic [W-1:0] port_b
);
    import sdm_pkg::*;

    logic [W-1:0] lane_q [N];
    lane_e        pick;

    // Lane selection: interleaved mode follows the phase; full-rate uses B.
    always_comb begin
        pick = dmux_mode ? lane_e'(phase_q) : LANE_B;
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        // Load this lane when it is the one selected on this edge.
        always_ff @(posedge clk) begin
            if (int'(pick) == g) begin
                lane_q[g] <= cap_q;
            end
        end
    end

    assign port_a = lane_q[int'(LANE_A)];
    assign port_b = lane_q[int'(LANE_B)];

    AST_B_HOLDS_ON_A_TURN: assert property (@(posedge clk) disable iff (!align_n)
        (dmux_mode && !phase_q) |=> $stable(port_b));                  // R4

    AST_A_HOLDS_ON_B_TURN: assert property (@(posedge clk) disable iff (!align_n)
        (dmux_mode && phase_q) |=> $stable(port_a));                   // R4

    AST_A_HOLDS_FULL_RATE: assert property (@(posedge clk) disable iff (!align_n)
        !dmux_mode |=> $stable(port_a));                               // R5
endmodule

// File: rtl/sample_demux.sv
// Module sample_demux
// Top level: capture stage, then lane steering, plus the half-rate phase.
// clk_out is the phase register in interleaved mode and the inverted
// sample clock in full-rate mode. Assumes that mode changes are applied
// away from the rising edge.
module sample_demux #(
    parameter int W = sdm_pkg::CODE_W
) (
    input  logic         clk,
    input  logic         align_n,
    input  logic         dmux_mode,
    input  logic         code_true,
    input  logic [W-1:0] sample_in,
    output logic [W-1:0] port_a,
    output logic [W-1:0] port_b,
    output logic         clk_out
);
    logic [W-1:0] cap_q;
    logic         phase_q;

    sdm_capture #(.W(W)) u_capture (
        .clk       (clk),
        .code_true (code_true),
        .sample_in (sample_in),
        .cap_q     (cap_q)
    );

    sdm_phase u_phase (
        .clk     (clk),
        .align_n (align_n),
        .phase_q (phase_q)
    );

    sdm_steer #(.W(W), .N(sdm_pkg::LANES)) u_steer (
        .clk       (clk),
        .align_n   (align_n),
        .dmux_mode (dmux_mode),
        .phase_q   (phase_q),
        .cap_q     (cap_q),
        .port_a    (port_a),
        .port_b    (port_b)
    );

    // Clock output selection between the half-rate and inverted clock.
    always_comb begin
        clk_out = dmux_mode ? phase_q : ~clk;
    end
endmodule

// File: tb/test_sample_demux.sv
// Bench test_sample_demux
// Directed tests, one task per scenario. Inputs change at falling edges;
// outputs are sampled 1 ns after a rising edge.
module test_sample_demux;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         align_n = 1'b0;
    logic         dmux_mode = 1'b1;
    logic         code_true = 1'b1;
    logic [W-1:0] sample_in = '0;
    logic [W-1:0] port_a, port_b;
    logic         clk_out;

    int n_tests = 0;
    int n_fail  = 0;

    sample_demux #(.W(W)) i_sample_demux (
        .clk       (clk),
        .align_n   (align_n),
        .dmux_mode (dmux_mode),
        .code_true (code_true),
        .sample_in (sample_in),
        .port_a    (port_a),
        .port_b    (port_b),
        .clk_out   (clk_out)
    );

    always #5 clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one sample at the falling edge, then sample 1 ns after the rising edge.
    task automatic tick(input logic [W-1:0] d);
        @(negedge clk);
        sample_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_align_hold();
        dmux_mode = 1'b1;
        align_n   = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(8'h00);
            check(clk_out == 1'b0, "R1 clk_out low while aligned", clk_out, 0);
        end
    endtask

    task automatic t_release_interleave(input logic [W-1:0] base);
        logic [W-1:0] ea, eb;
        @(negedge clk);
        align_n   = 1'b1;
        sample_in = base;
        @(posedge clk);
        #1;
        check(clk_out == 1'b1, "R2 clk_out high after release", clk_out, 1);
        eb = '0;
        ea = '0;
        for (int k = 1; k <= 8; k++) begin
            tick(base + W'(k));
            check(clk_out == k[0] ? 1'b0 : 1'b1, "R2 half-rate toggle", clk_out, k[0] ? 0 : 1);
            if (k[0]) begin
                eb = base + W'(k - 1);
                check(port_b == eb, "R3 port_b sample", port_b, eb);
                if (k > 1) check(port_a == ea, "R4 port_a stable at clk_out fall", port_a, ea);
            end else begin
                ea = base + W'(k - 1);
                check(port_a == ea, "R3 port_a sample", port_a, ea);
                check(port_b == eb, "R4 port_b stable at clk_out rise", port_b, eb);
            end
        end
    endtask

    task automatic t_long_align();
        @(negedge clk);
        align_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            check(clk_out == 1'b0, "R1 extended align period", clk_out, 0);
        end
        t_release_interleave(8'h40);
    endtask

    task automatic t_full_rate();
        logic [W-1:0] hold_a;
        @(negedge clk);
        dmux_mode = 1'b0;
        hold_a    = port_a;
        sample_in = 8'h80;
        @(posedge clk);
        #1;
        for (int k = 1; k <= 6; k++) begin
            tick(8'h80 + W'(k));
            check(port_b == 8'h80 + W'(k - 1), "R5 port_b full rate", port_b, 8'h80 + k - 1);
            check(port_a == hold_a, "R5 port_a holds", port_a, hold_a);
            check(clk_out == 1'b0, "R6 clk_out low while clk high", clk_out, 0);
            #5;
            check(clk_out == 1'b1, "R6 clk_out high while clk low", clk_out, 1);
        end
    endtask

    task automatic t_full_rate_align();
        @(negedge clk);
        align_n   = 1'b0;
        sample_in = 8'hC0;
        @(posedge clk);
        #1;
        for (int k = 1; k <= 4; k++) begin
            tick(8'hC0 + W'(k));
            check(port_b == 8'hC0 + W'(k - 1), "R7 align ignored by data", port_b, 8'hC0 + k - 1);
        end
        @(negedge clk);
        align_n = 1'b1;
    endtask

    task automatic t_polarity();
        @(negedge clk);
        dmux_mode = 1'b0;
        code_true = 1'b1;
        sample_in = 8'hFF;
        @(negedge clk);
        code_true = 1'b0;
        sample_in = 8'hFF;
        @(posedge clk);
        #1;
        check(port_b == 8'hFF, "R8 true full scale", port_b, 8'hFF);
        @(negedge clk);
        sample_in = 8'h00;
        @(posedge clk);
        #1;
        check(port_b == 8'h00, "R8 complemented full scale", port_b, 8'h00);
        @(negedge clk);
        sample_in = 8'h5A;
        @(posedge clk);
        #1;
        check(port_b == 8'hFF, "R8 complemented zero", port_b, 8'hFF);
        @(negedge clk);
        code_true = 1'b1;
        @(posedge clk);
        #1;
        check(port_b == 8'hA5, "R8 complemented pattern", port_b, 8'hA5);
        @(posedge clk);
        #1;
        check(port_b == 8'h5A, "R8 true pattern", port_b, 8'h5A);
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_align_hold();
        t_release_interleave(8'h10);
        t_long_align();
        t_full_rate();
        t_full_rate_align();
        t_polarity();
        @(negedge clk);
        dmux_mode = 1'b1;
        t_long_align();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule